// File: doc/BRIEF.md
# Indexed Configuration Register Bank

This block gives a host a bank of thirty 8-bit configuration registers through two addresses on a small I/O bus. One address is an index port. A write there loads a select register. The other address is a data port. A read or write there reaches the register named by the select register. The bus is decoded only while the `cfg_mode` input is high. The unlock sequence that raises that input sits outside this block.

Register 00 is the only register with behaviour. Its low two bits pick the function of a group of shared pins:
- disabled,
- a disk-interface function,
- an alternate infrared/interrupt function.

The same field also gates the pull-ups on those pins. Bit 3 controls power to the floppy controller. Bit 7 is a flag that only software uses. The remaining bits are fixed read-only patterns. Registers 01 to 29 are plain 8-bit storage.

There are two resets. The power-on reset loads all register defaults. The ordinary hardware reset clears only the select register, so configuration survives it. A strap input moves the two ports from the primary pair of addresses to the alternate pair.

Top module: `cfg_index_regbank`

## Requirements
- R1: With `alt_base` low, the index port is at address 03F0h and the data port is at 03F1h. A data-port read returns the register named by the last value written to the index port.
- R2: With `alt_base` high, the ports move to 0370h (index) and 0371h (data). Accesses to 03F0h and 03F1h are then ignored, and reads there return 00h.
- R3: While `cfg_mode` is low, writes to either port change nothing and `bus_rdata` reads 00h.
- R4: After power-on reset (`por_n` low), register 00 reads 28h, registers 01 to 29 read 00h and the index is 00h.
- R5: A hardware reset (`hrst_n` low) returns the index to 00h. It leaves every configuration register and the pin outputs unchanged.
- R6: In register 00, bit 2 always reads 0 and bits 6:4 always read 010b, whatever value is written.
- R7: Register 00 bits 1:0 select the pin function. 10b raises `ide_en`. 11b raises `alt_ir_en`. 00b and 01b raise neither.
- R8: `pullup_en` is high exactly when register 00 bit 1 is 0, that is for the codes 00b and 01b.
- R9: `fdc_pwrdn` is the inverse of register 00 bit 3. Bit 3 resets to 1, so the controller is powered.
- R10: Register 00 bit 7 reads back as written, resets to 0 and changes no output.
- R11: Index values above 29 (1Dh) read 00h, and data writes made with such an index change no register.
- R12: Registers 01 to 29 each store a full 8-bit value independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por_n | input | 1 | Power-on reset, asynchronous active-low |
| hrst_n | input | 1 | Hardware reset, asynchronous active-low; clears only the index |
| cfg_mode | input | 1 | High while configuration mode is active |
| alt_base | input | 1 | Strap selecting the alternate port pair |
| bus_addr | input | 16 | I/O address |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational; 00h when no data read is decoded |
| ide_en | output | 1 | Disk-interface pin function enabled |
| alt_ir_en | output | 1 | Alternate IR receive/transmit and interrupt pins enabled |
| pullup_en | output | 1 | Pull-ups on the shared pins enabled |
| fdc_pwrdn | output | 1 | Floppy controller low-power request |

## Verification
The hardest case to reach is one where the two resets must be told apart. The bench first writes non-default values into register 00 and into a storage register. It then pulses only `hrst_n` and reads everything back. The index must return to 00h while the stored contents and the pin outputs keep their values. A later `por_n` pulse must restore the defaults. The ignored-access cases also need deliberate setup. The bench leaves a known index in place, then writes with `cfg_mode` low, with the strap pointing the other way, and with an out-of-range index. After each attempt it reads back both the index and the neighbouring registers.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;
  localparam int unsigned DATA_W = 8;

  typedef enum logic [1:0] {
    IFM_OFF   = 2'b00,
    IFM_RSVD  = 2'b01,
    IFM_IDE   = 2'b10,
    IFM_ALTIR = 2'b11
  } ifmode_e;

  // register 00: writable bits and the fixed read-only pattern
  localparam logic [DATA_W-1:0] CR0_RW_MASK = 8'h8B;
  localparam logic [DATA_W-1:0] CR0_RO_VAL  = 8'h20;
  localparam logic [DATA_W-1:0] CR0_RST_RW  = 8'h08;
endpackage

// File: rtl/cfgbank_rst_sync.sv
module cfgbank_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = pipe_q[STAGES-1];
endmodule

// File: rtl/cfgbank_decode.sv
module cfgbank_decode
  import cfgbank_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] PRI_BASE = 16'h03F0,
  parameter logic [ADDR_W-1:0] ALT_BASE = 16'h0370
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_mode,
  input  logic              alt_base,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              dat_hit,
  output logic              dat_we,
  output logic [DATA_W-1:0] sel_q
);
  logic [ADDR_W-1:0] base;
  logic              idx_hit;
  logic              idx_we;
  logic [DATA_W-1:0] sel_d;

  assign base    = alt_base ? ALT_BASE : PRI_BASE;
  assign idx_hit = cfg_mode && (addr == base);
  assign dat_hit = cfg_mode && (addr == base + ADDR_W'(1));
  assign idx_we  = idx_hit && wr;
  assign dat_we  = dat_hit && wr;

  always_comb begin
    sel_d = sel_q;
    if (idx_we) sel_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_d;
  end

  p_idx_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode |=> $stable(sel_q));
  p_idx_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode && wr && addr == PRI_BASE && !alt_base) |=> sel_q == $past(wdata));
  p_idx_alt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode && wr && addr == PRI_BASE && alt_base) |=> $stable(sel_q));
endmodule

// File: rtl/cfgbank_cr00.sv
module cfgbank_cr00
  import cfgbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd,
  output logic              ide_en,
  output logic              alt_ir_en,
  output logic              pullup_en,
  output logic              fdc_pwrdn
);
  logic [DATA_W-1:0] rw_q, rw_d;
  ifmode_e           mode;

  always_comb begin
    rw_d = rw_q;
    if (we) rw_d = wdata & CR0_RW_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rw_q <= CR0_RST_RW;
    else        rw_q <= rw_d;
  end

  assign rd        = rw_q | CR0_RO_VAL;
  assign mode      = ifmode_e'(rw_q[1:0]);
  assign ide_en    = (mode == IFM_IDE);
  assign alt_ir_en = (mode == IFM_ALTIR);
  assign pullup_en = (mode == IFM_OFF) || (mode == IFM_RSVD);
  assign fdc_pwrdn = !rw_q[3];

  p_pwr_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> fdc_pwrdn == !$past(wdata[3]));
  p_mode_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wdata[1:0] == 2'b10) |=> ide_en && !alt_ir_en);
endmodule

// File: rtl/cfgbank_store.sv
module cfgbank_store
  import cfgbank_pkg::*;
#(
  parameter int unsigned NUM_REGS = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd
);
  localparam int unsigned LAST = NUM_REGS - 1;

  logic [DATA_W-1:0] mem_q [1:LAST];

  for (genvar g = 1; g <= LAST; g++) begin : g_reg
    logic              hit;
    logic [DATA_W-1:0] nxt;
    assign hit = we && (sel == DATA_W'(g));
    always_comb begin
      nxt = mem_q[g];
      if (hit) nxt = wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_q[g] <= '0;
      else        mem_q[g] <= nxt;
    end
  end

  always_comb begin
    rd = '0;
    for (int i = 1; i <= LAST; i++)
      if (sel == DATA_W'(i)) rd = mem_q[i];
  end
endmodule

// File: rtl/cfg_index_regbank.sv
module cfg_index_regbank
  import cfgbank_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned NUM_REGS = 30
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              hrst_n,
  input  logic              cfg_mode,
  input  logic              alt_base,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              ide_en,
  output logic              alt_ir_en,
  output logic              pullup_en,
  output logic              fdc_pwrdn
);
  localparam logic [DATA_W-1:0] LAST_IDX = DATA_W'(NUM_REGS - 1);

  logic              por_rn, sel_rn;
  logic              dat_hit, dat_we;
  logic [DATA_W-1:0] sel_q, cr0_rd, st_rd;
  logic              rd_active;

  cfgbank_rst_sync #(.STAGES(2)) u_por_sync (
    .clk(clk), .arst_n(por_n), .srst_n(por_rn));
  cfgbank_rst_sync #(.STAGES(2)) u_sel_sync (
    .clk(clk), .arst_n(por_n & hrst_n), .srst_n(sel_rn));

  cfgbank_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(sel_rn), .cfg_mode(cfg_mode), .alt_base(alt_base),
    .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .dat_hit(dat_hit), .dat_we(dat_we), .sel_q(sel_q));

  cfgbank_cr00 u_cr0 (
    .clk(clk), .rst_n(por_rn), .we(dat_we && sel_q == '0), .wdata(bus_wdata),
    .rd(cr0_rd), .ide_en(ide_en), .alt_ir_en(alt_ir_en),
    .pullup_en(pullup_en), .fdc_pwrdn(fdc_pwrdn));

  cfgbank_store #(.NUM_REGS(NUM_REGS)) u_store (
    .clk(clk), .rst_n(por_rn), .we(dat_we), .sel(sel_q),
    .wdata(bus_wdata), .rd(st_rd));

  assign rd_active = dat_hit && bus_rd;
  assign bus_rdata = !rd_active      ? '0 :
                     (sel_q == '0)   ? cr0_rd : st_rd;

  p_func_excl_r7: assert property (@(posedge clk) disable iff (!por_rn)
    $onehot0({ide_en, alt_ir_en}));
  p_pull_off_r8: assert property (@(posedge clk) disable iff (!por_rn)
    (ide_en || alt_ir_en) |-> !pullup_en);
  p_idle_rd_r3: assert property (@(posedge clk) disable iff (!por_rn)
    !cfg_mode |-> bus_rdata == '0);
  p_ro_bits_r6: assert property (@(posedge clk) disable iff (!por_rn)
    (rd_active && sel_q == '0) |-> (bus_rdata[6:4] == 3'b010 && !bus_rdata[2]));
  p_high_idx_r11: assert property (@(posedge clk) disable iff (!por_rn)
    (rd_active && sel_q > LAST_IDX) |-> bus_rdata == '0);
  p_hrst_keep_r5: assert property (@(posedge clk) disable iff (!por_rn)
    (!sel_rn && !bus_wr) |=> $stable(fdc_pwrdn) && $stable(pullup_en));
endmodule

// File: tb/cfg_index_regbank_tb_top.sv
`timescale 1ns/1ps
module cfg_index_regbank_tb_top;
  localparam logic [15:0] P_IDX = 16'h03F0, P_DAT = 16'h03F1;
  localparam logic [15:0] A_IDX = 16'h0370, A_DAT = 16'h0371;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } sb_item_t;

  logic clk = 1'b0;
  logic por_n, hrst_n, cfg_mode, alt_base, bus_wr, bus_rd;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic ide_en, alt_ir_en, pullup_en, fdc_pwrdn;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  sb_item_t sb_q[$];

  always #2 clk = ~clk;

  cfg_index_regbank dut_i (
    .clk(clk), .por_n(por_n), .hrst_n(hrst_n), .cfg_mode(cfg_mode),
    .alt_base(alt_base), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ide_en(ide_en),
    .alt_ir_en(alt_ir_en), .pullup_en(pullup_en), .fdc_pwrdn(fdc_pwrdn));

  // monitor: pops the expected read value while a read is on the bus
  always @(negedge clk) begin
    if (bus_rd) begin
      sb_item_t it;
      checks++;
      if (sb_q.size() == 0) begin
        fails++;
        $display("FAIL scoreboard empty: read %02h", bus_rdata);
      end else begin
        it = sb_q.pop_front();
        if (bus_rdata !== it.exp) begin
          fails++;
          $display("FAIL %s: rdata=%02h expected=%02h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, input logic [7:0] e, input string tag);
    sb_item_t it;
    @(posedge clk); #1;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic check_pins(input logic [3:0] e, input string tag);
    logic [3:0] act;
    act = {ide_en, alt_ir_en, pullup_en, fdc_pwrdn};
    checks++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s: pins(ide,alt,pull,pwrdn)=%b expected=%b", tag, act, e);
    end
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    #1;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    por_n = 1'b0; hrst_n = 1'b0; cfg_mode = 1'b0; alt_base = 1'b0;
    bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    repeat (3) @(posedge clk); #1;
    por_n = 1'b1; hrst_n = 1'b1;
    settle();

    check_pins(4'b0010, "R4 R8 R9 reset pins");
    bus_read(P_DAT, 8'h00, "R3 read outside cfg mode");
    cfg_mode = 1'b1;
    bus_read(P_DAT, 8'h28, "R4 R1 cr00 default");
    bus_write(P_IDX, 8'h05);
    bus_read(P_DAT, 8'h00, "R4 reg05 default");
    bus_write(P_DAT, 8'hA5);
    bus_read(P_DAT, 8'hA5, "R12 reg05 store");
    bus_write(P_IDX, 8'h1D);
    bus_write(P_DAT, 8'h3C);
    bus_read(P_DAT, 8'h3C, "R12 reg29 store");
    bus_write(P_IDX, 8'h05);
    bus_read(P_DAT, 8'hA5, "R12 reg05 independent");

    bus_write(P_IDX, 8'h00);
    bus_write(P_DAT, 8'hFF);
    bus_read(P_DAT, 8'hAB, "R6 R10 cr00 all ones");
    check_pins(4'b0100, "R7 R8 mode 11");
    bus_write(P_DAT, 8'h02);
    bus_read(P_DAT, 8'h22, "R6 cr00 mode 10 power off");
    check_pins(4'b1001, "R7 R9 mode 10 pwrdn");
    bus_write(P_DAT, 8'h01);
    check_pins(4'b0011, "R7 R8 mode 01 like 00");
    bus_write(P_DAT, 8'h88);
    bus_read(P_DAT, 8'hA8, "R10 valid bit readback");
    check_pins(4'b0010, "R10 valid bit no effect");

    bus_write(P_IDX, 8'h1E);
    bus_read(P_DAT, 8'h00, "R11 index 30 reads zero");
    bus_write(P_DAT, 8'h77);
    bus_write(P_IDX, 8'hFF);
    bus_read(P_DAT, 8'h00, "R11 index FF reads zero");
    bus_write(P_IDX, 8'h1D);
    bus_read(P_DAT, 8'h3C, "R11 reg29 unchanged");
    bus_write(P_IDX, 8'h00);
    bus_read(P_DAT, 8'hA8, "R11 cr00 unchanged");

    cfg_mode = 1'b0;
    bus_write(P_IDX, 8'h05);
    bus_write(P_DAT, 8'h02);
    cfg_mode = 1'b1;
    check_pins(4'b0010, "R3 pins after ignored write");
    bus_read(P_DAT, 8'hA8, "R3 index and cr00 unchanged");

    bus_write(P_IDX, 8'h05);
    alt_base = 1'b1;
    bus_write(P_IDX, 8'h1D);
    bus_read(A_DAT, 8'hA5, "R2 primary index ignored");
    bus_write(A_IDX, 8'h1D);
    bus_read(A_DAT, 8'h3C, "R2 alternate index");
    bus_read(P_DAT, 8'h00, "R2 primary data not decoded");

    hrst_n = 1'b0;
    repeat (2) @(posedge clk); #1;
    hrst_n = 1'b1;
    settle();
    bus_read(A_DAT, 8'hA8, "R5 index cleared cr00 kept");
    check_pins(4'b0010, "R5 pins kept");
    bus_write(A_IDX, 8'h05);
    bus_read(A_DAT, 8'hA5, "R5 reg05 kept");

    por_n = 1'b0;
    repeat (2) @(posedge clk); #1;
    por_n = 1'b1;
    settle();
    bus_read(A_DAT, 8'h28, "R4 cr00 default after por");
    bus_write(A_IDX, 8'h05);
    bus_read(A_DAT, 8'h00, "R4 reg05 default after por");

    repeat (2) @(posedge clk);
    if (sb_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard left %0d items", sb_q.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule